// File: doc/BRIEF.md
# Dual-Bank OUT Endpoint Receive Buffer

This block buffers the payload of data packets that arrive on one host-to-device endpoint and chooses the handshake each packet earns. It holds two payload banks, and each bank has a "received" flag. The packet side sets a bank's flag when a good packet lands in it. Software clears the flag once it has finished reading that bank. The flags decide which bank the next packet fills and whether the host is told ACK, NAK or nothing.

In single-bank mode only bank 0 is used. A packet that arrives while bank 0 is still full is refused and its payload is thrown away. In ping-pong mode, reception alternates between the two banks. Software can therefore read one bank while the host is already filling the other. A read pointer tells software which bank to drain next.

Isochronous traffic never receives a handshake. A packet that finds no free bank is dropped and recorded in a sticky overflow bit. Isochronous traffic is only valid in ping-pong mode.

Top module: `dual_bank_rx_ep`

## Requirements
- R1: A packet with good CRC that was admitted to a free bank sets that bank's flag and stores its byte count. In non-isochronous mode the handshake is ACK. `hs_code` encodes 2'b01 = ACK, 2'b10 = NAK and 2'b00 = none, and it is valid for exactly one cycle, in the cycle after the end strobe.
- R2: `irq` is high whenever `full0` or `full1` is set, and low otherwise.
- R3: In single-bank mode (`pingpong_en`=0), a packet that starts while `full0` is set gets NAK. The stored count and data of bank 0 stay unchanged, and bank 1 is never used.
- R4: A flag is cleared only by its clear pulse (`clr0`, `clr1`). After the clear, the bank accepts a new packet.
- R5: In ping-pong mode, the first packet after reset goes to bank 0 and the next goes to bank 1, and reception keeps alternating after that. If the bank due next is still full but the other bank is free, the packet goes to the free bank.
- R6: In ping-pong mode, a packet that starts while both flags are set gets NAK. No flag, count or data changes.
- R7: `sw_rd_data` returns byte `sw_rd_addr` of the bank selected by `sw_bank`. In ping-pong mode, `sw_bank` toggles when software clears the flag of the bank it selects, and a clear of the other bank leaves it unchanged. In single-bank mode, `sw_bank` is 0.
- R8: When `iso_en` is 1, no handshake is returned. A good packet that finds no free bank is dropped, and `iso_ovf` is set and stays set until reset.
- R9: `cfg_err` is high when `iso_en`=1 and `pingpong_en`=0. While it is high, packets change no flag and get no handshake.
- R10: Each bank stores at most 64 bytes. Extra bytes are discarded, the stored count stays at 64, and `trunc_ovf` is set and stays set until reset.
- R11: A packet whose `pk_crc_ok` is low at the end strobe gets no handshake and sets no flag. It does not advance the alternation, and the next packet is stored from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pingpong_en | input | 1 | 1 = two-bank operation, 0 = bank 0 only |
| iso_en | input | 1 | Isochronous traffic; suppresses the handshake |
| pk_start | input | 1 | Start of a data packet |
| pk_valid | input | 1 | `pk_data` holds a payload byte |
| pk_data | input | 8 | Payload byte |
| pk_end | input | 1 | End of packet; carries no byte |
| pk_crc_ok | input | 1 | CRC verdict, sampled with `pk_end` |
| hs_code | output | 2 | Handshake: 01 ACK, 10 NAK, 00 none |
| clr0 | input | 1 | Software clear pulse for bank 0's flag |
| clr1 | input | 1 | Software clear pulse for bank 1's flag |
| sw_rd_addr | input | 6 | Byte index for the software read |
| sw_rd_data | output | 8 | Byte read from bank `sw_bank` |
| sw_bank | output | 1 | Bank that software should read next |
| full0 | output | 1 | Bank 0 received flag |
| full1 | output | 1 | Bank 1 received flag |
| cnt0 | output | 7 | Bank 0 byte count |
| cnt1 | output | 7 | Bank 1 byte count |
| irq | output | 1 | Interrupt request |
| cfg_err | output | 1 | Isochronous mode requested without ping-pong |
| iso_ovf | output | 1 | Sticky: isochronous packet dropped |
| trunc_ovf | output | 1 | Sticky: packet longer than a bank |

## Verification
The assertions assume that the mode inputs stay fixed while a packet is in flight. They also assume that `pk_end` never arrives in the same cycle as a byte, and that a clear pulse is issued only for a bank that software has finished reading. The stimulus changes `pingpong_en` and `iso_en` only under reset, between test phases. It drives the start, byte and end strobes in separate cycles and clears banks only after reading them back. One phase deliberately clears the bank that `sw_bank` does not point to, to exercise the pointer rule.

// File: rtl/dual_bank_rx_ep.sv
module dual_bank_rx_ep #(
  parameter int MAX_BYTES = 64,
  parameter int DW = 8,
  localparam int AW = $clog2(MAX_BYTES),
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pingpong_en,
  input  logic          iso_en,
  input  logic          pk_start,
  input  logic          pk_valid,
  input  logic [DW-1:0] pk_data,
  input  logic          pk_end,
  input  logic          pk_crc_ok,
  output logic [1:0]    hs_code,
  input  logic          clr0,
  input  logic          clr1,
  input  logic [AW-1:0] sw_rd_addr,
  output logic [DW-1:0] sw_rd_data,
  output logic          sw_bank,
  output logic          full0,
  output logic          full1,
  output logic [CW-1:0] cnt0,
  output logic [CW-1:0] cnt1,
  output logic          irq,
  output logic          cfg_err,
  output logic          iso_ovf,
  output logic          trunc_ovf
);

  localparam logic [1:0] HS_NONE = 2'b00;
  localparam logic [1:0] HS_ACK  = 2'b01;
  localparam logic [1:0] HS_NAK  = 2'b10;
  localparam logic [CW-1:0] CAP  = CW'(MAX_BYTES);

  logic [DW-1:0] mem [2][MAX_BYTES];
  logic [1:0]    full;
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] wptr;
  logic          rx_ptr, in_pkt, acc, tgt;

  wire       bad_cfg  = iso_en & ~pingpong_en;
  wire [1:0] free     = ~full & {pingpong_en, 1'b1};
  wire       pick     = pingpong_en & (free[rx_ptr] ? rx_ptr : ~rx_ptr);
  wire       can_take = ~bad_cfg & free[pick];
  wire [1:0] clr      = {clr1, clr0};
  wire       byte_in  = in_pkt & ~pk_start & ~pk_end & pk_valid & acc;
  wire       wr_en    = byte_in & (wptr < CAP);
  wire       good_end = in_pkt & ~pk_start & pk_end & pk_crc_ok & ~bad_cfg;
  wire [1:0] set_vec  = (good_end & acc) ? (2'b01 << tgt) : 2'b00;

  assign full0      = full[0];
  assign full1      = full[1];
  assign cnt0       = cnt[0];
  assign cnt1       = cnt[1];
  assign irq        = |full;
  assign cfg_err    = bad_cfg;
  assign sw_rd_data = mem[sw_bank][sw_rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[tgt][wptr[AW-1:0]] <= pk_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 2'b00;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      wptr      <= '0;
      rx_ptr    <= 1'b0;
      sw_bank   <= 1'b0;
      in_pkt    <= 1'b0;
      acc       <= 1'b0;
      tgt       <= 1'b0;
      hs_code   <= HS_NONE;
      iso_ovf   <= 1'b0;
      trunc_ovf <= 1'b0;
    end else begin
      hs_code <= HS_NONE;
      full    <= (full & ~clr) | set_vec;

      if (pk_start) begin
        in_pkt <= 1'b1;
        acc    <= can_take;
        tgt    <= pick;
        wptr   <= '0;
      end else if (in_pkt && pk_end) begin
        in_pkt <= 1'b0;
        wptr   <= '0;
        if (good_end) begin
          if (acc) begin
            cnt[tgt] <= wptr;
            rx_ptr   <= pingpong_en & ~tgt;
            if (!iso_en) hs_code <= HS_ACK;
          end else if (iso_en) begin
            iso_ovf <= 1'b1;
          end else begin
            hs_code <= HS_NAK;
          end
        end
      end else if (byte_in) begin
        if (wptr < CAP) wptr <= wptr + 1'b1;
        else            trunc_ovf <= 1'b1;
      end

      if (!pingpong_en)                   sw_bank <= 1'b0;
      else if (clr[sw_bank] && full[sw_bank]) sw_bank <= ~sw_bank;
    end
  end

  AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == HS_ACK) |-> ((full & ~$past(full)) != 2'b00)); // R1

  AST_NAK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == HS_NAK) |-> ((full & ~$past(full)) == 2'b00)); // R6

  AST_FLAG0_CLEARED_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full[0]) |-> $past(clr0)); // R4

  AST_FLAG1_CLEARED_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full[1]) |-> $past(clr1)); // R4

  AST_SINGLE_NO_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pingpong_en && !$past(pingpong_en) && !$past(full[1])) |-> !full[1]); // R3

  AST_ISO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_en && $past(iso_en)) |-> (hs_code == HS_NONE)); // R8

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_cfg && $past(bad_cfg)) |-> (hs_code == HS_NONE && (full & ~$past(full)) == 2'b00)); // R9

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= CAP) && (cnt[1] <= CAP)); // R10

  AST_HS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code != HS_NONE) |=> (hs_code == HS_NONE)); // R1

endmodule

// File: tb/test_dual_bank_rx_ep.sv
`timescale 1ns/1ps
module test_dual_bank_rx_ep;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pingpong_en = 1'b0, iso_en = 1'b0;
  logic       pk_start = 1'b0, pk_valid = 1'b0, pk_end = 1'b0, pk_crc_ok = 1'b0;
  logic [7:0] pk_data = '0;
  logic [1:0] hs_code;
  logic       clr0 = 1'b0, clr1 = 1'b0;
  logic [5:0] sw_rd_addr = '0;
  logic [7:0] sw_rd_data;
  logic       sw_bank, full0, full1, irq, cfg_err, iso_ovf, trunc_ovf;
  logic [6:0] cnt0, cnt1;

  int checks = 0, failures = 0;
  logic [1:0] hs;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_bank_rx_ep i_dual_bank_rx_ep (
    .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .iso_en(iso_en),
    .pk_start(pk_start), .pk_valid(pk_valid), .pk_data(pk_data), .pk_end(pk_end),
    .pk_crc_ok(pk_crc_ok), .hs_code(hs_code), .clr0(clr0), .clr1(clr1),
    .sw_rd_addr(sw_rd_addr), .sw_rd_data(sw_rd_data), .sw_bank(sw_bank),
    .full0(full0), .full1(full1), .cnt0(cnt0), .cnt1(cnt1), .irq(irq),
    .cfg_err(cfg_err), .iso_ovf(iso_ovf), .trunc_ovf(trunc_ovf));

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic int capn(int n);
    return (n > 64) ? 64 : n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(bit pp, bit iso);
    @(negedge clk);
    rst_n = 1'b0; pingpong_en = pp; iso_en = iso;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_pkt(int len, int seed, bit crc, output logic [1:0] h);
    @(negedge clk) pk_start = 1'b1;
    @(negedge clk) pk_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      pk_valid = 1'b1; pk_data = pat(seed, i);
      @(negedge clk);
    end
    pk_valid = 1'b0; pk_end = 1'b1; pk_crc_ok = crc;
    @(negedge clk);
    pk_end = 1'b0; pk_crc_ok = 1'b0;
    h = hs_code;
  endtask

  task automatic clear(int b);
    @(negedge clk);
    if (b == 0) clr0 = 1'b1; else clr1 = 1'b1;
    @(negedge clk);
    clr0 = 1'b0; clr1 = 1'b0;
  endtask

  task automatic mism(int n, int seed, output int m);
    m = 0;
    for (int i = 0; i < n; i++) begin
      sw_rd_addr = 6'(i);
      #0.1;
      if (sw_rd_data != pat(seed, i)) m++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int m;
    do_reset(1'b0, 1'b0);
    chk(irq == 0 && full0 == 0 && full1 == 0, "R2 reset irq/flags", {irq, full1, full0}, 0);
    chk(hs_code == 2'b00 && sw_bank == 0, "R1 reset handshake", hs_code, 0);
    chk(cfg_err == 0 && iso_ovf == 0 && trunc_ovf == 0, "R9 reset status", {cfg_err, iso_ovf, trunc_ovf}, 0);

    // single-bank sweep over packet lengths
    for (int len = 0; len <= 66; len++) begin
      send_pkt(len, len, 1'b1, hs);
      chk(hs == 2'b01, "R1 ack single", hs, 1);
      chk(full0 == 1 && full1 == 0 && irq == 1, "R2 irq with flag", {irq, full1, full0}, 5);
      chk(cnt0 == 7'(capn(len)), "R10 count cap", cnt0, capn(len));
      chk(trunc_ovf == (len > 64), "R10 trunc sticky", trunc_ovf, (len > 64));
      mism(capn(len), len, m);
      chk(m == 0, "R7 read data", m, 0);
      send_pkt(5, len + 100, 1'b1, hs);
      chk(hs == 2'b10, "R3 nak single busy", hs, 2);
      chk(cnt0 == 7'(capn(len)) && full1 == 0, "R3 count kept", cnt0, capn(len));
      mism(capn(len), len, m);
      chk(m == 0, "R3 data kept", m, 0);
      clear(0);
      chk(full0 == 0 && irq == 0 && sw_bank == 0, "R4 clear frees", {sw_bank, irq, full0}, 0);
    end

    // bad CRC in single-bank mode
    do_reset(1'b0, 1'b0);
    send_pkt(9, 3, 1'b0, hs);
    chk(hs == 2'b00 && full0 == 0, "R11 bad crc silent", {hs, full0}, 0);
    send_pkt(4, 7, 1'b1, hs);
    chk(hs == 2'b01 && cnt0 == 4, "R11 rewound count", cnt0, 4);
    mism(4, 7, m);
    chk(m == 0, "R11 data after rewind", m, 0);

    // ping-pong rounds
    do_reset(1'b1, 1'b0);
    send_pkt(6, 50, 1'b0, hs);
    chk(hs == 2'b00 && full0 == 0 && full1 == 0, "R11 bad crc pp", {hs, full1, full0}, 0);
    for (int r = 0; r < 6; r++) begin
      send_pkt(10 + r, 200 + r, 1'b1, hs);
      chk(hs == 2'b01 && full0 == 1 && full1 == 0 && cnt0 == 7'(10 + r), "R5 first to bank0", cnt0, 10 + r);
      send_pkt(20 + r, 300 + r, 1'b1, hs);
      chk(hs == 2'b01 && full1 == 1 && cnt1 == 7'(20 + r), "R5 next to bank1", cnt1, 20 + r);
      send_pkt(3, 400 + r, 1'b1, hs);
      chk(hs == 2'b10, "R6 nak both full", hs, 2);
      chk(cnt0 == 7'(10 + r) && cnt1 == 7'(20 + r) && full0 && full1, "R6 nothing changed", cnt0, 10 + r);
      chk(sw_bank == 0, "R7 pointer bank0", sw_bank, 0);
      mism(10 + r, 200 + r, m);
      chk(m == 0, "R7 read bank0", m, 0);
      clear(0);
      chk(sw_bank == 1 && full0 == 0 && irq == 1, "R7 pointer toggles", sw_bank, 1);
      mism(20 + r, 300 + r, m);
      chk(m == 0, "R7 read bank1", m, 0);
      clear(1);
      chk(sw_bank == 0 && irq == 0, "R7 pointer back", sw_bank, 0);
    end

    // out-of-order clear: bank due next is full, other is free
    send_pkt(11, 1, 1'b1, hs);
    send_pkt(12, 2, 1'b1, hs);
    clear(1);
    chk(sw_bank == 0 && full1 == 0 && full0 == 1, "R7 other clear no toggle", sw_bank, 0);
    send_pkt(13, 3, 1'b1, hs);
    chk(hs == 2'b01 && full1 == 1 && cnt1 == 13 && cnt0 == 11, "R5 takes free bank", cnt1, 13);
    mism(11, 1, m);
    chk(m == 0, "R7 bank0 intact", m, 0);
    clear(0);
    mism(13, 3, m);
    chk(sw_bank == 1 && m == 0, "R7 read diverted", m, 0);
    clear(1);
    send_pkt(14, 4, 1'b1, hs);
    chk(full0 == 1 && full1 == 0 && cnt0 == 14, "R5 alternation resumes", cnt0, 14);

    // isochronous
    do_reset(1'b1, 1'b1);
    chk(cfg_err == 0, "R9 valid iso cfg", cfg_err, 0);
    send_pkt(8, 60, 1'b1, hs);
    chk(hs == 2'b00 && full0 == 1, "R8 iso no handshake", hs, 0);
    send_pkt(9, 61, 1'b1, hs);
    chk(hs == 2'b00 && full1 == 1 && iso_ovf == 0, "R8 iso bank1", iso_ovf, 0);
    send_pkt(10, 62, 1'b1, hs);
    chk(hs == 2'b00 && iso_ovf == 1, "R8 iso overflow", iso_ovf, 1);
    chk(cnt0 == 8 && cnt1 == 9, "R8 dropped packet", cnt0, 8);
    mism(8, 60, m);
    chk(m == 0, "R8 data kept", m, 0);
    clear(0);
    chk(iso_ovf == 1, "R8 overflow sticky", iso_ovf, 1);

    // invalid configuration
    do_reset(1'b0, 1'b1);
    chk(cfg_err == 1, "R9 cfg error", cfg_err, 1);
    send_pkt(5, 70, 1'b1, hs);
    chk(hs == 2'b00 && full0 == 0 && full1 == 0 && iso_ovf == 0, "R9 packet ignored", {hs, full1, full0}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule